// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block holds the configuration registers of a multi-port display overlay engine. Each configuration value that must change only between frames has two copies. A staging copy takes bus writes. A live copy drives the engine and is what the bus reads back. Registers that may change at any time have a single copy, which takes effect on the write.

Software stages a batch of changes and then arms one or more output ports through a done register. Each write to the done register carries a write mask, so one write can arm several ports. An armed port copies its staged values into the live copies on the next rising edge of its frame sync, and its armed flag then clears. Each window cluster follows the port selected by its own 2-bit routing field. The layer-select register follows the port named in a 2-bit source field of the overlay control register. An immediate-commit bit copies the per-port display settings into the live copies at once, but it leaves the window clusters untouched.

Top module: `shadow_commit_regs`

## Requirements
- R1: A write to a window shadow register (control 0 at +0x00, base at +0x04, stride at +0x08, active size at +0x0C, display info at +0x10 within cluster block 0x200 + c*0x40) does not change the read-back value. The read-back changes only on the clock edge that samples a rising vsync of the cluster's port while that port is armed. From then on the staged value reads back.
- R2: The done register is at 0x000. A write to it acts only if the enable bit 15 is 1. Port n is armed by bit n = 1 together with mask bit n+16 = 1. Reading 0x000 returns the armed flags in bits [NUM_PORTS-1:0] and zero elsewhere.
- R3: One done write can arm several ports. For example, 0x00058005 arms ports 0 and 2.
- R4: In a done write with the enable bit set, a port whose mask bit is 0 keeps its armed flag. A port whose mask bit is 1 and whose data bit is 0 is disarmed.
- R5: An armed flag clears on the edge where its port commits. A vsync on a port that is not armed commits nothing. Arming twice before one vsync gives exactly one commit.
- R6: The port-select register at 0x044 holds the routing of cluster c in bits [17+2c:16+2c]. A cluster commits only on the vsync of the port selected there.
- R7: The overlay control register at 0x040 names in bits [31:30] the port whose commit copies the layer-select register at 0x048 from staging to live. The value 2'b10 selects port 2.
- R8: Writing 1 to bit 28 of the global register at 0x030 copies every port's display control (port block 0x400 + p*0x20, offset +0x00) to live on that edge. The window clusters are not copied, and bit 28 reads back as 0.
- R9: Unstaged registers take effect on the write and read back the written value: window control 1 (+0x14), window display start (+0x18), port clock control (+0x04), 0x030, 0x040 and 0x044.
- R10: A cluster routed to a port whose vsync never rises keeps its reset value in read-back, even when other ports commit.
- R11: After reset, every register reads 0 and no port is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| vsync | input | NUM_PORTS | Per-port frame sync, synchronous to clk |
| win_state | output | NUM_CLUSTERS*7*DATA_W | Live window fields per cluster |
| port_dsp | output | NUM_PORTS*DATA_W | Live per-port display control |
| port_clk | output | NUM_PORTS*DATA_W | Per-port clock control |
| layer_sel | output | DATA_W | Live layer-select value |
| ovl_ctrl | output | DATA_W | Overlay control value |
| port_route | output | DATA_W | Port-select (routing) value |

## Verification
Every fault in this block shows up at the bus read-back, or on the live outputs, one clock edge after the vsync edge or write that should have caused it. A flag that was not cleared is visible at address 0x000 right after the commit edge. A second vsync then shows it as an unexpected second copy. A routing or source-field decode error shows up as a live value that moves on the wrong port's vsync, or that never moves. The directed scenarios therefore pulse each vsync on its own and read back after every step.

// File: rtl/shc_pkg.sv
package shc_pkg;
   localparam int FLD_NUM       = 7;
   localparam int SH_NUM        = 5;
   localparam int SEL_W         = 2;
   localparam int DONE_EN_BIT   = 15;
   localparam int DONE_MASK_LSB = 16;
   localparam int IMM_BIT       = 28;
   localparam int LSRC_LSB      = 30;
   localparam int ROUTE_LSB     = 16;
   localparam int WIN_SPAN      = 64;
   localparam int PORT_SPAN     = 32;

   localparam logic [11:0] A_DONE  = 12'h000;
   localparam logic [11:0] A_GLB   = 12'h030;
   localparam logic [11:0] A_OVL   = 12'h040;
   localparam logic [11:0] A_ROUTE = 12'h044;
   localparam logic [11:0] A_LSEL  = 12'h048;
   localparam logic [11:0] A_WIN0  = 12'h200;
   localparam logic [11:0] A_PORT0 = 12'h400;

   typedef enum logic [2:0] {
      F_CTRL0  = 3'd0,
      F_BASE   = 3'd1,
      F_STRIDE = 3'd2,
      F_SIZE   = 3'd3,
      F_INFO   = 3'd4,
      F_CTRL1  = 3'd5,
      F_START  = 3'd6
   } win_field_e;
endpackage

// File: rtl/shc_arm.sv
module shc_arm #(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_we,
   input  logic                 done_en,
   input  logic [NUM_PORTS-1:0] arm_data,
   input  logic [NUM_PORTS-1:0] arm_mask,
   input  logic [NUM_PORTS-1:0] vsync,
   output logic [NUM_PORTS-1:0] pending,
   output logic [NUM_PORTS-1:0] commit
);
   logic [NUM_PORTS-1:0] vs_q;
   logic [NUM_PORTS-1:0] touch;
   logic [NUM_PORTS-1:0] pending_nx;

   assign commit = pending & vsync & ~vs_q;
   assign touch  = (done_we && done_en) ? arm_mask : '0;

   always_comb begin
      pending_nx = (pending & ~commit & ~touch) | (touch & arm_data);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q    <= '0;
         pending <= '0;
      end else begin
         vs_q    <= vsync;
         pending <= pending_nx;
      end
   end
endmodule

// File: rtl/shc_src_pick.sv
module shc_src_pick #(
   parameter int NUM_PORTS = 4,
   parameter int SEL_W     = 2
) (
   input  logic [NUM_PORTS-1:0] commits,
   input  logic [SEL_W-1:0]     sel,
   output logic                 fire
);
   localparam int PADW = 1 << SEL_W;
   logic [PADW-1:0] pad;

   generate
      if (NUM_PORTS >= PADW) begin : g_trim
         assign pad = commits[PADW-1:0];
      end else begin : g_fill
         assign pad = {{(PADW-NUM_PORTS){1'b0}}, commits};
      end
   endgenerate

   assign fire = pad[sel];
endmodule

// File: rtl/shc_win_bank.sv
module shc_win_bank
   import shc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_PORTS = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [FLD_NUM-1:0]              fld_we,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [NUM_PORTS-1:0]            port_commit,
   input  logic [SEL_W-1:0]                route,
   output logic                            commit,
   output logic [FLD_NUM-1:0][DATA_W-1:0]  view
);
   shc_src_pick #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_pick (
      .commits (port_commit),
      .sel     (route),
      .fire    (commit)
   );

   for (genvar f = 0; f < FLD_NUM; f++) begin : g_fld
      if (f < SH_NUM) begin : g_staged
         logic [DATA_W-1:0] stage_q;
         logic [DATA_W-1:0] live_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
               live_q  <= '0;
            end else begin
               if (fld_we[f]) stage_q <= wdata;
               if (commit)    live_q  <= stage_q;
            end
         end
         assign view[f] = live_q;
      end else begin : g_direct
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         val_q <= '0;
            else if (fld_we[f]) val_q <= wdata;
         end
         assign view[f] = val_q;
      end
   end
endmodule

// File: rtl/shc_port_bank.sv
module shc_port_bank #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsp_we,
   input  logic              clk_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic              imm,
   output logic [DATA_W-1:0] dsp_live,
   output logic [DATA_W-1:0] clk_val
);
   logic [DATA_W-1:0] dsp_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsp_stage <= '0;
         dsp_live  <= '0;
         clk_val   <= '0;
      end else begin
         if (dsp_we)          dsp_stage <= wdata;
         if (commit || imm)   dsp_live  <= dsp_stage;
         if (clk_we)          clk_val   <= wdata;
      end
   end
endmodule

// File: rtl/shadow_commit_regs.sv
module shadow_commit_regs
   import shc_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int NUM_PORTS    = 4,
   parameter int NUM_CLUSTERS = 2
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [ADDR_W-1:0]                            bus_addr,
   input  logic [DATA_W-1:0]                            bus_wdata,
   input  logic                                         bus_we,
   output logic [DATA_W-1:0]                            bus_rdata,
   input  logic [NUM_PORTS-1:0]                         vsync,
   output logic [NUM_CLUSTERS-1:0][FLD_NUM-1:0][DATA_W-1:0] win_state,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]             port_dsp,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]             port_clk,
   output logic [DATA_W-1:0]                            layer_sel,
   output logic [DATA_W-1:0]                            ovl_ctrl,
   output logic [DATA_W-1:0]                            port_route
);
   localparam int ROUTE_TOP = ROUTE_LSB + SEL_W * NUM_CLUSTERS;

   if (DATA_W < 32) begin : g_chk_dw
      $error("DATA_W must be at least 32");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > (1 << SEL_W)) begin : g_chk_np
      $error("NUM_PORTS must fit the 2-bit select fields");
   end
   if (ROUTE_TOP > 32 || NUM_CLUSTERS < 1) begin : g_chk_nc
      $error("NUM_CLUSTERS routing fields exceed the register");
   end
   if (ADDR_W < 11) begin : g_chk_aw
      $error("ADDR_W too small for the register map");
   end

   logic                                    wr_done, wr_glb, wr_ovl, wr_route, wr_lsel;
   logic                                    done_en, imm_fire, layer_commit;
   logic [NUM_PORTS-1:0]                    arm_data, arm_mask, pending, port_commit;
   logic [NUM_CLUSTERS-1:0]                 win_commit;
   logic [NUM_CLUSTERS-1:0][FLD_NUM-1:0]    win_we;
   logic [NUM_PORTS-1:0]                    dsp_we, pclk_we;
   logic [DATA_W-1:0]                       glb_q, lsel_stage;

   assign wr_done  = bus_we && (bus_addr == ADDR_W'(A_DONE));
   assign wr_glb   = bus_we && (bus_addr == ADDR_W'(A_GLB));
   assign wr_ovl   = bus_we && (bus_addr == ADDR_W'(A_OVL));
   assign wr_route = bus_we && (bus_addr == ADDR_W'(A_ROUTE));
   assign wr_lsel  = bus_we && (bus_addr == ADDR_W'(A_LSEL));
   assign done_en  = bus_wdata[DONE_EN_BIT];
   assign arm_data = bus_wdata[NUM_PORTS-1:0];
   assign arm_mask = bus_wdata[DONE_MASK_LSB +: NUM_PORTS];
   assign imm_fire = wr_glb && bus_wdata[IMM_BIT];

   shc_arm #(.NUM_PORTS(NUM_PORTS)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_we  (wr_done),
      .done_en  (done_en),
      .arm_data (arm_data),
      .arm_mask (arm_mask),
      .vsync    (vsync),
      .pending  (pending),
      .commit   (port_commit)
   );

   for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_win
      for (genvar f = 0; f < FLD_NUM; f++) begin : g_we
         assign win_we[c][f] = bus_we &&
            (bus_addr == ADDR_W'(32'(A_WIN0) + c * WIN_SPAN + f * 4));
      end
      shc_win_bank #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .fld_we      (win_we[c]),
         .wdata       (bus_wdata),
         .port_commit (port_commit),
         .route       (port_route[ROUTE_LSB + SEL_W*c +: SEL_W]),
         .commit      (win_commit[c]),
         .view        (win_state[c])
      );
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign dsp_we[p]  = bus_we &&
         (bus_addr == ADDR_W'(32'(A_PORT0) + p * PORT_SPAN));
      assign pclk_we[p] = bus_we &&
         (bus_addr == ADDR_W'(32'(A_PORT0) + p * PORT_SPAN + 4));
      shc_port_bank #(.DATA_W(DATA_W)) u_pbank (
         .clk      (clk),
         .rst_n    (rst_n),
         .dsp_we   (dsp_we[p]),
         .clk_we   (pclk_we[p]),
         .wdata    (bus_wdata),
         .commit   (port_commit[p]),
         .imm      (imm_fire),
         .dsp_live (port_dsp[p]),
         .clk_val  (port_clk[p])
      );
   end

   shc_src_pick #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_lsrc (
      .commits (port_commit),
      .sel     (ovl_ctrl[LSRC_LSB +: SEL_W]),
      .fire    (layer_commit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q      <= '0;
         ovl_ctrl   <= '0;
         port_route <= '0;
         lsel_stage <= '0;
         layer_sel  <= '0;
      end else begin
         if (wr_glb) begin
            glb_q          <= bus_wdata;
            glb_q[IMM_BIT] <= 1'b0;
         end
         if (wr_ovl)       ovl_ctrl   <= bus_wdata;
         if (wr_route)     port_route <= bus_wdata;
         if (wr_lsel)      lsel_stage <= bus_wdata;
         if (layer_commit) layer_sel  <= lsel_stage;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_DONE))  bus_rdata = DATA_W'(pending);
      if (bus_addr == ADDR_W'(A_GLB))   bus_rdata = glb_q;
      if (bus_addr == ADDR_W'(A_OVL))   bus_rdata = ovl_ctrl;
      if (bus_addr == ADDR_W'(A_ROUTE)) bus_rdata = port_route;
      if (bus_addr == ADDR_W'(A_LSEL))  bus_rdata = layer_sel;
      for (int c = 0; c < NUM_CLUSTERS; c++) begin
         for (int f = 0; f < FLD_NUM; f++) begin
            if (bus_addr == ADDR_W'(32'(A_WIN0) + c * WIN_SPAN + f * 4))
               bus_rdata = win_state[c][f];
         end
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (bus_addr == ADDR_W'(32'(A_PORT0) + p * PORT_SPAN))
            bus_rdata = port_dsp[p];
         if (bus_addr == ADDR_W'(32'(A_PORT0) + p * PORT_SPAN + 4))
            bus_rdata = port_clk[p];
      end
   end
endmodule

// File: rtl/shc_checker.sv
module shc_checker
   import shc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int NUM_PORTS    = 4,
   parameter int NUM_CLUSTERS = 2
) (
   input logic                                             clk,
   input logic                                             rst_n,
   input logic                                             wr_done,
   input logic                                             done_en,
   input logic [NUM_PORTS-1:0]                             arm_data,
   input logic [NUM_PORTS-1:0]                             arm_mask,
   input logic [NUM_PORTS-1:0]                             pending,
   input logic [NUM_PORTS-1:0]                             port_commit,
   input logic [NUM_CLUSTERS-1:0]                          win_commit,
   input logic                                             layer_commit,
   input logic                                             imm_fire,
   input logic [NUM_CLUSTERS-1:0][FLD_NUM-1:0][DATA_W-1:0] win_state,
   input logic [DATA_W-1:0]                                layer_sel
);
   for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_c
      AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !win_commit[c] |=> $stable(win_state[c][1])) else $error("win hold"); // R1
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (port_commit[p] && !(wr_done && done_en && arm_mask[p] && arm_data[p]))
         |=> !pending[p]) else $error("pending clear"); // R5
   end

   AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && !done_en && port_commit == '0) |=> $stable(pending))
      else $error("arm enable"); // R2

   AST_IMM_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_fire && win_commit == '0) |=> $stable(win_state))
      else $error("imm window"); // R8

   AST_LSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !layer_commit |=> $stable(layer_sel)) else $error("layer hold"); // R7
endmodule

bind shadow_commit_regs shc_checker #(
   .DATA_W       (DATA_W),
   .NUM_PORTS    (NUM_PORTS),
   .NUM_CLUSTERS (NUM_CLUSTERS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_done      (wr_done),
   .done_en      (done_en),
   .arm_data     (arm_data),
   .arm_mask     (arm_mask),
   .pending      (pending),
   .port_commit  (port_commit),
   .win_commit   (win_commit),
   .layer_commit (layer_commit),
   .imm_fire     (imm_fire),
   .win_state    (win_state),
   .layer_sel    (layer_sel)
);

// File: tb/tb_shadow_commit_regs.sv
module tb_shadow_commit_regs;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12, DW = 32, NP = 4, NC = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [AW-1:0]        bus_addr = '0;
   logic [DW-1:0]        bus_wdata = '0;
   logic                 bus_we = 1'b0;
   logic [DW-1:0]        bus_rdata;
   logic [NP-1:0]        vsync = '0;
   logic [NC-1:0][6:0][DW-1:0] win_state;
   logic [NP-1:0][DW-1:0] port_dsp, port_clk;
   logic [DW-1:0]        layer_sel, ovl_ctrl, port_route;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadow_commit_regs #(.ADDR_W(AW), .DATA_W(DW), .NUM_PORTS(NP), .NUM_CLUSTERS(NC)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .vsync(vsync),
      .win_state(win_state), .port_dsp(port_dsp), .port_clk(port_clk),
      .layer_sel(layer_sel), .ovl_ctrl(ovl_ctrl), .port_route(port_route)
   );

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic pulse(input int p);
      @(negedge clk);
      vsync[p] = 1'b1;
      @(negedge clk);
      vsync[p] = 1'b0;
   endtask

   task automatic t_reset();
      rd_check("R11 done", 12'h000, 32'h0);
      rd_check("R11 base", 12'h204, 32'h0);
      rd_check("R11 dsp", 12'h400, 32'h0);
   endtask

   task automatic t_stage_commit();
      wr(12'h204, 32'h0000_1234);
      rd_check("R1 staged only", 12'h204, 32'h0);
      pulse(0);
      rd_check("R5 unarmed vsync", 12'h204, 32'h0);
      wr(12'h000, 32'h0001_8001);
      rd_check("R2 armed flag", 12'h000, 32'h1);
      rd_check("R1 armed no vsync", 12'h204, 32'h0);
      pulse(0);
      rd_check("R1 committed", 12'h204, 32'h0000_1234);
      rd_check("R5 flag cleared", 12'h000, 32'h0);
   endtask

   task automatic t_enable();
      wr(12'h000, 32'h0001_0001);
      rd_check("R2 no enable", 12'h000, 32'h0);
   endtask

   task automatic t_multi_mask();
      wr(12'h000, 32'h0005_8005);
      rd_check("R3 two ports", 12'h000, 32'h5);
      wr(12'h000, 32'h0004_8001);
      rd_check("R4 masked keep", 12'h000, 32'h1);
      wr(12'h000, 32'h0001_8000);
      rd_check("R4 disarm", 12'h000, 32'h0);
   endtask

   task automatic t_rearm();
      wr(12'h208, 32'h40);
      wr(12'h000, 32'h0001_8001);
      wr(12'h000, 32'h0001_8001);
      pulse(0);
      rd_check("R5 rearm commit", 12'h208, 32'h40);
      rd_check("R5 rearm cleared", 12'h000, 32'h0);
      wr(12'h208, 32'h80);
      pulse(0);
      rd_check("R5 single commit", 12'h208, 32'h40);
   endtask

   task automatic t_route();
      wr(12'h044, 32'h0008_0000);
      rd_check("R9 route rb", 12'h044, 32'h0008_0000);
      wr(12'h248, 32'h780);
      wr(12'h000, 32'h0001_8001);
      pulse(0);
      rd_check("R6 wrong port", 12'h248, 32'h0);
      wr(12'h000, 32'h0004_8004);
      pulse(2);
      rd_check("R6 routed port", 12'h248, 32'h780);
   endtask

   task automatic t_direct();
      wr(12'h214, 32'h0000_dead);
      rd_check("R9 ctrl1", 12'h214, 32'h0000_dead);
      wr(12'h404, 32'h2);
      rd_check("R9 port clk", 12'h404, 32'h2);
      check("R9 port clk out", port_clk[0], 32'h2);
   endtask

   task automatic t_idle_port();
      wr(12'h044, 32'h000B_0000);
      wr(12'h20C, 32'h0437_077f);
      wr(12'h000, 32'h0009_8009);
      pulse(0);
      rd_check("R10 idle port", 12'h20C, 32'h0);
      rd_check("R10 still armed", 12'h000, 32'h8);
   endtask

   task automatic t_layer();
      wr(12'h040, 32'h8000_0000);
      wr(12'h048, 32'hAB);
      wr(12'h000, 32'h0001_8001);
      pulse(0);
      rd_check("R7 other port", 12'h048, 32'h0);
      wr(12'h000, 32'h0004_8004);
      pulse(2);
      rd_check("R7 source port", 12'h048, 32'hAB);
      check("R7 live out", layer_sel, 32'hAB);
   endtask

   task automatic t_immediate();
      wr(12'h420, 32'h1000_000f);
      wr(12'h250, 32'h55);
      rd_check("R8 before imm", 12'h420, 32'h0);
      wr(12'h030, 32'h1000_0000);
      rd_check("R8 port dsp", 12'h420, 32'h1000_000f);
      rd_check("R8 window untouched", 12'h250, 32'h0);
      rd_check("R8 bit not stored", 12'h030, 32'h0);
      rd_check("R8 flags kept", 12'h000, 32'h8);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stage_commit();
      t_enable();
      t_multi_mask();
      t_rearm();
      t_route();
      t_direct();
      t_idle_port();
      t_layer();
      t_immediate();
      finished = 1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=done");
         summary();
      end
   end
endmodule